// File: doc/BRIEF.md
# Bus Master Latency Timer

This block limits how long a bus master may keep the bus after it has lost its grant. Software programs a byte-wide count, in bus clock cycles, through a small configuration write/read port. Each time the master starts a transaction by raising its frame signal, the block loads that count and counts down one step per bus clock. The count stops at zero and does not wrap.

If the master ends the transaction before the count reaches zero, the timer has no effect. Reaching zero does not end the transaction on its own. The block asks for termination only when two things are true together: the count has run out, and the arbiter has withdrawn the grant. The request is a single-cycle pulse, and it is raised at most once per transaction.

All inputs are active high. The reset is synchronous. Address phases, data phases, arbitration and the target side are handled elsewhere.

Top module: `bm_lat_timer`

## Requirements
- R1: While `rst` is high, the programmed count becomes 0x00 and `term_req` becomes low. Both values are visible on the first cycle after a reset edge.
- R2: A clock edge with `cfg_wr_en` high stores `cfg_wr_data`. From the next cycle on, `cfg_rd_data` shows the stored value until the next write.
- R3: A transaction starts on a clock edge where `frame_act` is high and was low at the previous edge. That edge loads the programmed count L. Each later edge with `frame_act` still high lowers the count by one. With `grant` held low throughout, `term_req` is high only after edge L+2, counting the start edge as edge 1.
- R4: A programmed count of 0 makes the timer expired right after the start edge. With `grant` low, `term_req` goes high after the second edge.
- R5: While `grant` is high, `term_req` stays low, even after expiry. After expiry, the first edge that samples `grant` low raises `term_req`. A short drop of `grant` before expiry raises nothing.
- R6: If `frame_act` falls before the count reaches zero, `term_req` stays low for that transaction.
- R7: Once the count reaches zero, it stays at zero while `frame_act` is held high, even for more than 256 cycles. A later drop of `grant` still raises `term_req`.
- R8: `term_req` is high for exactly one cycle, at most once per transaction.
- R9: No edge that samples `frame_act` low raises `term_req`. Dropping `frame_act` and `grant` at the same edge after expiry gives no request.
- R10: A write to the count during a transaction has no effect on that transaction. The new value is used from the next start edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Writes the programmed count |
| cfg_wr_data | input | LT_W | Count value to write |
| cfg_rd_data | output | LT_W | Currently programmed count |
| frame_act | input | 1 | Master frame asserted (high = transaction running) |
| grant | input | 1 | Bus grant from the arbiter (high = granted) |
| term_req | output | 1 | One-cycle request to terminate the transaction |

## Verification
The checker assumes a few things about the inputs:
- `frame_act` and `grant` are synchronous to `clk` and never unknown once reset is released.
- A new transaction is always preceded by at least one cycle with `frame_act` low.
- Configuration writes may happen at any time.

The stimulus changes every input only on the falling clock edge. Between transactions it always returns `frame_act` low for at least two cycles. It never holds `grant` or `frame_act` unknown, so the start-edge detection and the grant sampling see clean values.

// File: rtl/bmlt_pkg.sv
package bmlt_pkg;

    localparam int unsigned LT_W_DEF = 8;

    // Per-cycle view of the master's frame signal
    typedef struct packed {
        logic start;   // first cycle of a transaction
        logic busy;    // transaction in progress
    } frame_evt_t;

    // Termination sequencing within one transaction
    typedef enum logic [1:0] {
        TP_IDLE  = 2'd0,
        TP_WATCH = 2'd1,
        TP_FIRE  = 2'd2,
        TP_SPENT = 2'd3
    } term_phase_t;

    function automatic term_phase_t next_phase(
        input term_phase_t cur,
        input logic        busy,
        input logic        expired,
        input logic        granted
    );
        term_phase_t nxt;
        nxt = cur;
        if (!busy) begin
            nxt = TP_IDLE;
        end else begin
            unique case (cur)
                TP_IDLE:  nxt = TP_WATCH;
                TP_WATCH: nxt = (expired && !granted) ? TP_FIRE : TP_WATCH;
                TP_FIRE:  nxt = TP_SPENT;
                TP_SPENT: nxt = TP_SPENT;
                default:  nxt = TP_IDLE;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bmlt_cfg_reg.sv
module bmlt_cfg_reg #(
    parameter int unsigned W = bmlt_pkg::LT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end
    end
endmodule

// File: rtl/bmlt_frame_mon.sv
module bmlt_frame_mon
    import bmlt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_act,
    output frame_evt_t evt
);
    logic frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b0;
        end else begin
            frame_q <= frame_act;
        end
    end

    always_comb begin
        evt.start = frame_act && !frame_q;
        evt.busy  = frame_act;
    end
endmodule

// File: rtl/bmlt_down_cnt.sv
module bmlt_down_cnt
    import bmlt_pkg::*;
#(
    parameter int unsigned W = LT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  frame_evt_t   evt,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         expired
);
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = W'(1);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_ZERO;
            armed_q <= 1'b0;
        end else if (evt.start) begin
            cnt_q   <= load_val;
            armed_q <= 1'b1;
        end else if (!evt.busy) begin
            armed_q <= 1'b0;
        end else if (armed_q && (cnt_q != CNT_ZERO)) begin
            cnt_q <= cnt_q - CNT_ONE;   // stops at zero, never wraps
        end
    end

    assign expired = armed_q && (cnt_q == CNT_ZERO);
endmodule

// File: rtl/bmlt_term_gen.sv
module bmlt_term_gen
    import bmlt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    input  logic       expired,
    input  logic       grant,
    output logic       term_req
);
    term_phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= TP_IDLE;
        end else begin
            phase_q <= next_phase(phase_q, evt.busy, expired, grant);
        end
    end

    assign term_req = (phase_q == TP_FIRE);
endmodule

// File: rtl/bm_lat_timer.sv
module bm_lat_timer
    import bmlt_pkg::*;
#(
    parameter int unsigned LT_W = LT_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr_en,
    input  logic [LT_W-1:0] cfg_wr_data,
    output logic [LT_W-1:0] cfg_rd_data,
    input  logic            frame_act,
    input  logic            grant,
    output logic            term_req
);
    frame_evt_t      evt;
    logic [LT_W-1:0] limit_val;
    logic [LT_W-1:0] cnt_q;
    logic            expired;

    bmlt_cfg_reg #(.W(LT_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .value   (limit_val)
    );

    bmlt_frame_mon u_fmon (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .evt       (evt)
    );

    bmlt_down_cnt #(.W(LT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .load_val (limit_val),
        .cnt_q    (cnt_q),
        .expired  (expired)
    );

    bmlt_term_gen u_term (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .expired  (expired),
        .grant    (grant),
        .term_req (term_req)
    );

    assign cfg_rd_data = limit_val;
endmodule

// File: rtl/bm_lat_timer_chk.sv
module bm_lat_timer_chk #(
    parameter int unsigned LT_W = bmlt_pkg::LT_W_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_wr_en,
    input logic [LT_W-1:0] cfg_wr_data,
    input logic [LT_W-1:0] cfg_rd_data,
    input logic            frame_act,
    input logic            grant,
    input logic            term_req,
    input logic [LT_W-1:0] cnt_q,
    input logic            expired,
    input logic            start
);
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (cfg_rd_data == '0) && !term_req);                              // R1

    AST_WR_STORE: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));                       // R2

    AST_TERM_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(term_req) |-> $past(expired));                                    // R3

    AST_TERM_NEEDS_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(term_req) |-> !$past(grant));                                     // R5

    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && frame_act && !start) |=> cnt_q == '0);                  // R7

    AST_TERM_PULSE: assert property (@(posedge clk) disable iff (rst)
        term_req |=> !term_req);                                                // R8

    AST_TERM_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(term_req) |-> $past(frame_act));                                  // R9
endmodule

bind bm_lat_timer bm_lat_timer_chk #(.LT_W(LT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .frame_act   (frame_act),
    .grant       (grant),
    .term_req    (term_req),
    .cnt_q       (cnt_q),
    .expired     (expired),
    .start       (evt.start)
);

// File: tb/bm_lat_timer_tb_top.sv
module bm_lat_timer_tb_top;
    localparam int unsigned LT_W = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr_en = 1'b0;
    logic [LT_W-1:0] cfg_wr_data = '0;
    logic [LT_W-1:0] cfg_rd_data;
    logic            frame_act = 1'b0;
    logic            grant = 1'b1;
    logic            term_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bm_lat_timer #(.LT_W(LT_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .frame_act   (frame_act),
        .grant       (grant),
        .term_req    (term_req)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_limit(input int v);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = LT_W'(v);
        tick(1);
        cfg_wr_en = 1'b0;
        chk("R2 readback", int'(cfg_rd_data), v);
    endtask

    task automatic end_frame();
        frame_act = 1'b0;
        grant     = 1'b1;
        tick(2);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        chk("R1 reset count", int'(cfg_rd_data), 0);
        chk("R1 reset term", int'(term_req), 0);
        rst = 1'b0;
        tick(1);
    endtask

    // R2: several write patterns
    task automatic t_regs();
        program_limit(8'hA5);
        program_limit(8'h00);
        program_limit(8'hFF);
        tick(3);
        chk("R2 hold", int'(cfg_rd_data), 8'hFF);
    endtask

    // R3/R4/R8: grant low from the start, request only after edge L+2
    task automatic t_timed(input int lim, input string req);
        program_limit(lim);
        grant     = 1'b0;
        frame_act = 1'b1;
        for (int k = 1; k <= lim + 8; k++) begin
            tick(1);
            chk(req, int'(term_req), (k == lim + 2) ? 1 : 0);
        end
        end_frame();
    endtask

    // R5: grant held through expiry, early short drop ignored
    task automatic t_grant_hold();
        program_limit(2);
        grant     = 1'b1;
        frame_act = 1'b1;
        tick(1);
        grant = 1'b0;          // edge 2 sees grant low, count not yet zero
        tick(1);
        chk("R5 early drop", int'(term_req), 0);
        grant = 1'b1;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            chk("R5 grant high", int'(term_req), 0);
        end
        grant = 1'b0;
        tick(1);
        chk("R5 grant withdrawn", int'(term_req), 1);
        tick(1);
        chk("R8 pulse end", int'(term_req), 0);
        end_frame();
    endtask

    // R6: frame ends before expiry
    task automatic t_early_end();
        program_limit(5);
        grant     = 1'b0;
        frame_act = 1'b1;
        tick(4);
        frame_act = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            chk("R6 no request", int'(term_req), 0);
        end
        end_frame();
    endtask

    // R7: held long past any wrap
    task automatic t_saturate();
        program_limit(2);
        grant     = 1'b1;
        frame_act = 1'b1;
        tick(300);
        chk("R7 quiet while granted", int'(term_req), 0);
        grant = 1'b0;
        tick(1);
        chk("R7 still expired", int'(term_req), 1);
        end_frame();
    endtask

    // R9: frame and grant fall together
    task automatic t_frame_cancel();
        program_limit(1);
        grant     = 1'b1;
        frame_act = 1'b1;
        tick(4);
        frame_act = 1'b0;
        grant     = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick(1);
            chk("R9 no request", int'(term_req), 0);
        end
        end_frame();
    endtask

    // R10: mid-transaction write only affects the next transaction
    task automatic t_midwrite();
        program_limit(6);
        grant     = 1'b0;
        frame_act = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            tick(1);
            if (k == 2) cfg_wr_en = 1'b0;
            chk("R10 current", int'(term_req), (k == 8) ? 1 : 0);
            if (k == 1) begin
                cfg_wr_en   = 1'b1;
                cfg_wr_data = LT_W'(1);
            end
        end
        end_frame();
        grant     = 1'b0;
        frame_act = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            tick(1);
            chk("R10 next", int'(term_req), (k == 3) ? 1 : 0);
        end
        end_frame();
    endtask

    initial begin
        tick(1);
        t_reset();
        t_regs();
        t_timed(3, "R3 timing");
        t_timed(0, "R4 zero count");
        t_timed(1, "R8 single pulse");
        t_grant_hold();
        t_early_end();
        t_saturate();
        t_frame_cancel();
        t_midwrite();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule